// File: doc/BRIEF.md
# Codec Command Verb Decoder and Responder

This block is the command side of an audio codec's control path. Each frame the link layer hands it one 32-bit command word. The block compares the top nibble of the word with its own codec address, splits out the target node and the verb, updates a few control registers held by the codec's nodes, and returns a 32-bit response word one cycle later. Commands for other codecs are dropped without trace.

Four nodes are implemented: a root node, a function-group node, a connection selector node and an amplifier node. The function-group node holds a 2-bit power state and three 4-bit GPIO registers (data, enable mask, direction). The selector node holds an 8-bit connection index. The amplifier node holds a mute bit and a 7-bit gain for an output amplifier and for an input amplifier. Every implemented node answers parameter reads from a fixed table. Any verb or node the block does not implement gets an all-zero response.

The default node numbers are root 00h, function group 01h, amplifier 08h and selector 0Ch. The default codec address is 2h.

Top module: `verb_responder`

## Requirements
- R1: A command with `cmd_valid` high and `cmd_word[31:28]` equal to the codec address produces `rsp_valid` high on the next cycle only. `rsp_valid` is low in every cycle that does not follow such a command.
- R2: A command whose address nibble does not match produces no response and changes no register.
- R3: Bits [27:20] are the node ID. When bits [19:16] are 7h or Fh, the verb is the 12-bit ID in [19:8] with an 8-bit payload in [7:0]. Otherwise the verb is the 4-bit ID in [19:16] with a 16-bit payload in [15:0].
- R4: An unknown node, or a verb that the addressed node does not implement, gets an all-zero response and changes no register.
- R5: On the function-group node, verb 705h writes payload[1:0] to the power state (00 = D0, 01 = D1, 10 = D2, 11 = D3). Verb F05h returns it in response bits [1:0], with bits [31:2] zero.
- R6: On the function-group node, verbs 715h, 716h and 717h write payload[3:0] to GPIO data, enable mask and direction, and payload[7:4] is ignored. Verbs F15h, F16h and F17h return the matching register in bits [3:0], with bits [31:4] zero.
- R7: On the selector node, verb 701h writes the 8-bit payload to the connection index. Verb F01h returns it in bits [7:0], with the rest zero.
- R8: On the amplifier node, the short verb 3h updates the output amplifier when payload bit 15 is set and the input amplifier when bit 14 is set. In both cases it writes mute from bit 7 and gain from bits [6:0]. The short verb Bh reads the output amplifier when payload bit 15 is 1 and the input amplifier when it is 0. The response carries mute in bit 7 and gain in bits [6:0], with bits [31:8] zero.
- R9: Verb F00h on any implemented node returns a table entry selected by the 8-bit payload: 00h gives the vendor word, 02h the revision word, 04h 00010001h, 0Fh 0000000Fh and 11h 00000004h. Any other ID returns zero.
- R10: After reset the power state is D0, all GPIO registers are 0, the connection index is 0, and both amplifiers are muted with gain 0, so a gain read returns 80h.
- R11: Every 12-bit set verb (bits [19:16] = 7h) is answered with an all-zero response word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command word is present this cycle |
| cmd_word | input | 32 | Command word |
| rsp_valid | output | 1 | A response word is present this cycle |
| rsp_word | output | 32 | Response word |

## Verification
All register state is visible only through get verbs. A corrupted register therefore shows up in the response word to the next matching get, exactly one cycle after that get is issued. A write that lands in the wrong register, or a foreign command that alters state, stays hidden until a read of the victim register. For this reason the bench reads back every register after writes to neighbouring registers, after foreign commands and after unsupported commands. Faults in address matching or response framing appear at once as an extra or missing `rsp_valid` in the cycle after the command.

// File: rtl/verb_pkg.sv
package verb_pkg;
    localparam int CMD_W   = 32;
    localparam int ADDR_W  = 4;
    localparam int NID_W   = 8;
    localparam int VID_W   = 12;
    localparam int SID_W   = 4;
    localparam int PAY_W   = 16;
    localparam int PS_W    = 2;
    localparam int GPIO_W  = 4;
    localparam int GPIO_N  = 3;
    localparam int CONN_W  = 8;
    localparam int GAIN_W  = 7;
    localparam int NID_LSB = CMD_W - ADDR_W - NID_W;
    localparam int VID_LSB = NID_LSB - VID_W;

    localparam logic [VID_W-1:0] V_GET_PARAM = 12'hF00;
    localparam logic [VID_W-1:0] V_GET_CONN  = 12'hF01;
    localparam logic [VID_W-1:0] V_SET_CONN  = 12'h701;
    localparam logic [VID_W-1:0] V_GET_PWR   = 12'hF05;
    localparam logic [VID_W-1:0] V_SET_PWR   = 12'h705;
    localparam logic [VID_W-1:0] V_GET_GPIO0 = 12'hF15;
    localparam logic [VID_W-1:0] V_SET_GPIO0 = 12'h715;
    localparam logic [SID_W-1:0] S_SET_AMP   = 4'h3;
    localparam logic [SID_W-1:0] S_GET_AMP   = 4'hB;
    localparam logic [SID_W-1:0] S_LONG_SET  = 4'h7;
    localparam logic [SID_W-1:0] S_LONG_GET  = 4'hF;

    typedef struct packed {
        logic              hit;
        logic [NID_W-1:0]  nid;
        logic              is_long;
        logic [VID_W-1:0]  vid;
        logic [SID_W-1:0]  sid;
        logic [PAY_W-1:0]  pay;
    } dec_t;

    typedef struct packed {
        logic              mute;
        logic [GAIN_W-1:0] gain;
    } amp_t;

    typedef struct packed {
        logic [PS_W-1:0]                pwr;
        logic [GPIO_N-1:0][GPIO_W-1:0]  gpio;
        logic [CONN_W-1:0]              conn;
        amp_t                           amp_out;
        amp_t                           amp_in;
        logic                           rsp_v;
        logic [CMD_W-1:0]               rsp;
    } state_t;
endpackage

// File: rtl/verb_decode.sv
module verb_decode
    import verb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CODEC_ADDR = 4'h2
) (
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output dec_t             dec
);
    always_comb begin
        dec.hit     = cmd_valid && (cmd_word[CMD_W-1 -: ADDR_W] == CODEC_ADDR);
        dec.nid     = cmd_word[NID_LSB +: NID_W];
        dec.vid     = cmd_word[VID_LSB +: VID_W];
        dec.sid     = cmd_word[NID_LSB-1 -: SID_W];
        dec.pay     = cmd_word[PAY_W-1:0];
        dec.is_long = (dec.sid == S_LONG_SET) || (dec.sid == S_LONG_GET);
    end
endmodule

// File: rtl/verb_params.sv
module verb_params
    import verb_pkg::*;
#(
    parameter logic [CMD_W-1:0] VENDOR_WORD = 32'h1357_0001,
    parameter logic [CMD_W-1:0] REV_WORD    = 32'h0010_0100,
    parameter logic [NID_W-1:0] FG_NID      = 8'h01
) (
    input  logic [7:0]       pid,
    output logic [CMD_W-1:0] val
);
    localparam logic [CMD_W-1:0] NODE_RANGE = {8'h00, FG_NID, 8'h00, 8'h01};
    localparam logic [CMD_W-1:0] PWR_SUP    = CMD_W'((1 << (1 << PS_W)) - 1);
    localparam logic [CMD_W-1:0] GPIO_CAP   = CMD_W'(GPIO_W);

    always_comb begin
        case (pid)
            8'h00:   val = VENDOR_WORD;
            8'h02:   val = REV_WORD;
            8'h04:   val = NODE_RANGE;
            8'h0F:   val = PWR_SUP;
            8'h11:   val = GPIO_CAP;
            default: val = '0;
        endcase
    end
endmodule

// File: rtl/verb_responder.sv
module verb_responder
    import verb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CODEC_ADDR  = 4'h2,
    parameter logic [NID_W-1:0]  ROOT_NID    = 8'h00,
    parameter logic [NID_W-1:0]  FG_NID      = 8'h01,
    parameter logic [NID_W-1:0]  AMP_NID     = 8'h08,
    parameter logic [NID_W-1:0]  MUX_NID     = 8'h0C,
    parameter logic [CMD_W-1:0]  VENDOR_WORD = 32'h1357_0001,
    parameter logic [CMD_W-1:0]  REV_WORD    = 32'h0010_0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             rsp_valid,
    output logic [CMD_W-1:0] rsp_word
);
    dec_t             dec;
    logic [CMD_W-1:0] param_val;
    logic             node_known;
    state_t           s_d, s_q, s_rst;

    verb_decode #(.CODEC_ADDR(CODEC_ADDR)) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .dec       (dec)
    );

    verb_params #(
        .VENDOR_WORD (VENDOR_WORD),
        .REV_WORD    (REV_WORD),
        .FG_NID      (FG_NID)
    ) u_params (
        .pid (dec.pay[7:0]),
        .val (param_val)
    );

    assign node_known = (dec.nid == ROOT_NID) || (dec.nid == FG_NID) ||
                        (dec.nid == AMP_NID)  || (dec.nid == MUX_NID);

    always_comb begin
        s_rst = '0;
        s_rst.amp_out.mute = 1'b1;
        s_rst.amp_in.mute  = 1'b1;
    end

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = dec.hit;
        s_d.rsp   = '0;
        if (dec.hit && node_known) begin
            if (dec.is_long && dec.vid == V_GET_PARAM) begin
                s_d.rsp = param_val;
            end else if (dec.nid == FG_NID && dec.is_long) begin
                if (dec.vid == V_SET_PWR) s_d.pwr = dec.pay[PS_W-1:0];
                if (dec.vid == V_GET_PWR) s_d.rsp = CMD_W'(s_q.pwr);
                for (int k = 0; k < GPIO_N; k++) begin
                    if (dec.vid == V_SET_GPIO0 + VID_W'(k))
                        s_d.gpio[k] = dec.pay[GPIO_W-1:0];
                    if (dec.vid == V_GET_GPIO0 + VID_W'(k))
                        s_d.rsp = CMD_W'(s_q.gpio[k]);
                end
            end else if (dec.nid == MUX_NID && dec.is_long) begin
                if (dec.vid == V_SET_CONN) s_d.conn = dec.pay[CONN_W-1:0];
                if (dec.vid == V_GET_CONN) s_d.rsp  = CMD_W'(s_q.conn);
            end else if (dec.nid == AMP_NID && !dec.is_long) begin
                if (dec.sid == S_SET_AMP) begin
                    if (dec.pay[15]) s_d.amp_out = amp_t'(dec.pay[GAIN_W:0]);
                    if (dec.pay[14]) s_d.amp_in  = amp_t'(dec.pay[GAIN_W:0]);
                end
                if (dec.sid == S_GET_AMP)
                    s_d.rsp = CMD_W'(dec.pay[15] ? s_q.amp_out : s_q.amp_in);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= s_rst;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.rsp_v;
    assign rsp_word  = s_q.rsp;
endmodule

// File: rtl/verb_responder_chk.sv
module verb_responder_chk
    import verb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CODEC_ADDR = 4'h2,
    parameter logic [NID_W-1:0]  ROOT_NID   = 8'h00,
    parameter logic [NID_W-1:0]  FG_NID     = 8'h01,
    parameter logic [NID_W-1:0]  AMP_NID    = 8'h08,
    parameter logic [NID_W-1:0]  MUX_NID    = 8'h0C
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [CMD_W-1:0] cmd_word,
    input logic             rsp_valid,
    input logic [CMD_W-1:0] rsp_word
);
    logic             hit;
    logic [NID_W-1:0] nid;
    logic             known;
    assign hit   = cmd_valid && (cmd_word[31:28] == CODEC_ADDR);
    assign nid   = cmd_word[27:20];
    assign known = (nid == ROOT_NID) || (nid == FG_NID) || (nid == AMP_NID) || (nid == MUX_NID);

    AST_RSP_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> rsp_valid); // R1
    AST_NO_RSP_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !rsp_valid); // R2
    AST_UNKNOWN_NODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !known) |=> (rsp_word == '0)); // R4
    AST_SET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cmd_word[19:16] == 4'h7) |=> (rsp_word == '0)); // R11
    AST_PWR_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && nid == FG_NID && cmd_word[19:8] == 12'hF05) |=> (rsp_word[31:2] == '0)); // R5
    AST_GPIO_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && nid == FG_NID && cmd_word[19:8] >= 12'hF15 && cmd_word[19:8] <= 12'hF17)
        |=> (rsp_word[31:4] == '0)); // R6
    AST_AMP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && nid == AMP_NID && cmd_word[19:16] == 4'hB) |=> (rsp_word[31:8] == '0)); // R8
endmodule

bind verb_responder verb_responder_chk #(
    .CODEC_ADDR (CODEC_ADDR),
    .ROOT_NID   (ROOT_NID),
    .FG_NID     (FG_NID),
    .AMP_NID    (AMP_NID),
    .MUX_NID    (MUX_NID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .rsp_valid (rsp_valid),
    .rsp_word  (rsp_word)
);

// File: tb/verb_responder_bench.sv
`timescale 1ns/1ps
module verb_responder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        rsp_valid;
    logic [31:0] rsp_word;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    verb_responder u_verb_responder (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word)
    );

    // {requirement number, command, expected response}
    localparam int NV = 42;
    localparam logic [71:0] VEC [0:NV-1] = '{
        72'h05_20170503_00000000, // R5 set D3
        72'h05_201F0500_00000003, // R5 read D3
        72'h05_201705FE_00000000, // R5 upper payload bits dropped
        72'h05_201F0500_00000002, // R5 reads D2
        72'h06_201715A5_00000000, // R6 data
        72'h06_201F1500_00000005, // R6
        72'h06_2017163C_00000000, // R6 mask
        72'h06_201F1600_0000000C, // R6
        72'h06_201717F9_00000000, // R6 direction
        72'h06_201F1700_00000009, // R6
        72'h07_20C70101_00000000, // R7
        72'h07_20CF0100_00000001, // R7
        72'h07_20C7017E_00000000, // R7
        72'h07_20CF0100_0000007E, // R7
        72'h08_20838025_00000000, // R8 output only
        72'h08_208B8000_00000025, // R8
        72'h08_208B0000_00000080, // R8 input untouched
        72'h08_20834091_00000000, // R8 input only
        72'h08_208B0000_00000091, // R8
        72'h08_208B8000_00000025, // R8 output untouched
        72'h08_2083C005_00000000, // R8 both
        72'h08_208B8000_00000005, // R8
        72'h08_208B0000_00000005, // R8
        72'h09_200F0000_13570001, // R9 vendor
        72'h09_200F0002_00100100, // R9 revision
        72'h09_200F0004_00010001, // R9 node range
        72'h09_201F000F_0000000F, // R9 power states
        72'h09_201F0011_00000004, // R9 GPIO count
        72'h09_208F0033_00000000, // R9 unknown id
        72'h04_208F0500_00000000, // R4 power read on amp node
        72'h04_201B8000_00000000, // R4 amp read on function group
        72'h04_230F0000_00000000, // R4 unknown node
        72'h04_201F9900_00000000, // R4 unknown long verb
        72'h04_20820000_00000000, // R4 unknown short verb
        72'h04_20C70502_00000000, // R4 power write on selector
        72'h04_201F0500_00000002, // R4 power unchanged
        72'h04_208B8000_00000005, // R4 amp unchanged
        72'h04_20170101_00000000, // R4 selector write on function group
        72'h04_20CF0100_0000007E, // R4 index unchanged
        72'h03_2013C07F_00000000, // R3 short form on function group
        72'h03_201F0500_00000002, // R3 power unchanged
        72'h09_200F0500_00000000  // R9 root has no power register
    };

    task automatic issue(input logic [31:0] c, output logic v, output logic [31:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = c;
        @(negedge clk);
        v = rsp_valid;
        w = rsp_word;
        cmd_valid = 1'b0;
    endtask

    task automatic expect_rsp(input logic [31:0] c, input logic [31:0] exp, input string req);
        logic v;
        logic [31:0] w;
        issue(c, v, w);
        checks++;
        if (!v || w !== exp) begin
            errors++;
            $display("FAIL %s cmd=%h got valid=%0b word=%h expected valid=1 word=%h", req, c, v, w, exp);
        end
    endtask

    task automatic expect_none(input logic [31:0] c, input string req);
        logic v;
        logic [31:0] w;
        issue(c, v, w);
        checks++;
        if (v !== 1'b0) begin
            errors++;
            $display("FAIL %s cmd=%h got valid=%0b expected valid=0", req, c, v);
        end
    endtask

    task automatic reset_checks(input string req);
        expect_rsp(32'h201F0500, 32'h0, req);
        expect_rsp(32'h201F1500, 32'h0, req);
        expect_rsp(32'h201F1600, 32'h0, req);
        expect_rsp(32'h201F1700, 32'h0, req);
        expect_rsp(32'h20CF0100, 32'h0, req);
        expect_rsp(32'h208B8000, 32'h80, req);
        expect_rsp(32'h208B0000, 32'h80, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 got no completion expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic v;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset rsp_valid got %0b expected 0", rsp_valid);
        end
        rst_n = 1'b1;
        reset_checks("R10");

        for (int i = 0; i < NV; i++) begin
            expect_rsp(VEC[i][63:32], VEC[i][31:0], $sformatf("R%0d vec%0d", VEC[i][71:64], i));
        end

        // R1: exactly one response, none in the cycle after
        issue(32'h201F0500, v, w);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 second-cycle valid got %0b expected 0", rsp_valid);
        end

        // R2: foreign address, no response, no state change
        expect_none(32'h30170501, "R2");
        expect_none(32'h00838000, "R2");
        expect_none(32'hF0C70155, "R2");
        expect_rsp(32'h201F0500, 32'h2, "R2");
        expect_rsp(32'h208B8000, 32'h5, "R2");
        expect_rsp(32'h20CF0100, 32'h7E, "R2");

        // R11: write on a supported verb answers zero
        expect_rsp(32'h20170501, 32'h0, "R11");
        expect_rsp(32'h201F0500, 32'h1, "R11");

        // R10: reset mid-run restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        reset_checks("R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule